// File: doc/BRIEF.md
# Collision Retransmit DMA Controller

This block is the transmit engine of a half-duplex Ethernet MAC. A start pulse gives it the address of a frame in local buffer memory, the frame length and the number of frames in a chain. The frames of a chain sit back to back in memory. The block reads bytes through a byte-wide DMA read port and sends them, one per clock, on a transmit byte stream. It waits for the medium to be idle before every attempt.

When a collision input rises during the early part of an attempt, the block stops sending data and sends a short jam. It then waits a random, exponentially growing number of slot times and sends the same frame again from its first byte. It does this without host help. A collision late in the frame, or too many collisions in a row, aborts the frame and ends the chain. Each frame ends with a one-cycle done or abort pulse. With the pulse the block gives the number of collisions the frame took.

Top module: `txr_retry_dma`

## Requirements
- R1: After reset, `busy`, `tx_valid`, `tx_done` and `tx_abort` are low and `attempts` is 0.
- R2: A frame is sent as `frame_len` bytes read from ascending addresses, starting at its base address, one byte per clock while `tx_valid` is high. It ends with a one-cycle `tx_done` pulse, and `attempts` then holds the number of collisions that frame took.
- R3: An attempt (the first attempt or a retry) begins only while `medium_idle` is high. While the block waits with `medium_idle` low, no byte is sent.
- R4: A collision seen while fewer than `SLOT_BYTES` data bytes of the current attempt have been sent stops the data at once. Exactly 4 jam bytes of value 0xAA follow, and then the block backs off and retries.
- R5: With `medium_idle` held high, the number of idle clocks between the last jam byte and the first retry byte is r*`SLOT_BYTES` + 2. Here r is an integer with 0 <= r <= 2^k - 1, k = min(collisions so far in this frame, `BO_LIMIT`), and r comes from a 16-bit LFSR.
- R6: Each retry rewinds the read pointer to the base address of the current frame, so the frame is sent again from its first byte.
- R7: A chain of `chain_len` frames is sent in order. After a frame completes, the next base address is the address that follows the last byte of that frame. A retry repeats only the frame in progress.
- R8: A collision seen once `SLOT_BYTES` or more data bytes of the attempt have been sent is followed by the 4-byte jam and then a `tx_abort` pulse with `abort_late`=1. There is no retry, and the rest of the chain is dropped.
- R9: A frame is allowed up to `MAX_RETRY` (15) retries. On its 16th collision the block sends the jam, then pulses `tx_abort` with `abort_late`=0 and `attempts`=16, and the chain ends.
- R10: `tx_done` and `tx_abort` never pulse in the same cycle. The collision counter never exceeds `MAX_RETRY`+1 and is cleared for each new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a chain (accepted when not busy) |
| start_addr | input | ADDR_W | Base address of the first frame |
| frame_len | input | LEN_W | Bytes per frame (at least 1) |
| chain_len | input | CHAIN_W | Frames in the chain (at least 1) |
| medium_idle | input | 1 | Link is free for an attempt |
| col | input | 1 | Collision detected |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_addr | output | ADDR_W | Buffer read address |
| mem_rd_data | input | 8 | Buffer read data, same cycle as address |
| tx_valid | output | 1 | Byte on `tx_data` is sent this cycle |
| tx_data | output | 8 | Transmit byte |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: frame given up |
| abort_late | output | 1 | Last abort came from a late collision |
| attempts | output | ATT_W | Collisions taken by the last finished frame |
| busy | output | 1 | A chain is in progress |

## Verification
On every cycle the assertions check several rules. Done and abort never coincide. The collision counter stays within its cap. No byte leaves while the block waits on a busy medium, and a jam byte follows every accepted collision. Each retry starts with the read pointer equal to the frame base, and the base register moves only on a start or a completed frame. Other properties need whole scenarios, which the bench builds. These are the exact byte order across retries and chained frames, the boundary between early and late collision at the slot edge, the abort after the 16th collision, and the arithmetic form of every backoff gap.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_SEND = 3'd2,
    S_JAM  = 3'd3,
    S_BACK = 3'd4
  } txr_state_e;

  localparam logic [7:0] JAM_BYTE = 8'hAA;
  localparam int         JAM_LEN  = 4;

endpackage

// File: rtl/txr_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
module txr_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] rnd
);

  logic [W-1:0] s_q, s_n;

  always_comb begin
    s_n = {1'b0, s_q[W-1:1]};
    if (s_q[0]) s_n = s_n ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= s_n;
  end

  assign rnd = s_q;

endmodule

// File: rtl/txr_backoff.sv
// Truncated binary exponential backoff timer, counted in slot times.
module txr_backoff #(
  parameter int SLOT_BYTES = 64,
  parameter int BO_LIMIT   = 10,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] ncol,
  input  logic [15:0]      rnd,
  output logic             done
);

  localparam int TICK_W = (SLOT_BYTES > 2) ? $clog2(SLOT_BYTES) : 1;

  logic [BO_LIMIT-1:0] mask, draw;
  logic [BO_LIMIT-1:0] slots_q, slots_n;
  logic [TICK_W-1:0]   tick_q, tick_n;
  logic                run_q, run_n;

  // exponent k = min(ncol, BO_LIMIT); mask holds k low ones
  always_comb begin
    for (int i = 0; i < BO_LIMIT; i++) begin
      mask[i] = (32'(ncol) > i);
    end
    draw = rnd[BO_LIMIT-1:0] & mask;
  end

  assign done = run_q && (slots_q == '0);

  always_comb begin
    run_n   = run_q;
    slots_n = slots_q;
    tick_n  = tick_q;
    if (load) begin
      run_n   = 1'b1;
      slots_n = draw;
      tick_n  = '0;
    end else if (run_q) begin
      if (slots_q == '0) begin
        run_n = 1'b0;
      end else if (tick_q == TICK_W'(SLOT_BYTES - 1)) begin
        tick_n  = '0;
        slots_n = slots_q - BO_LIMIT'(1);
      end else begin
        tick_n = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      slots_q <= '0;
      tick_q  <= '0;
    end else begin
      run_q   <= run_n;
      slots_q <= slots_n;
      tick_q  <= tick_n;
    end
  end

endmodule

// File: rtl/txr_addr.sv
// Per-frame base register and DMA current pointer.
module txr_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              rewind,
  input  logic              commit,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0] base_n, cur_n, cur_inc;

  assign cur_inc = cur_addr + ADDR_W'(1);

  always_comb begin
    base_n = base_addr;
    cur_n  = cur_addr;
    if (load) begin
      base_n = load_val;
      cur_n  = load_val;
    end else begin
      if (step)   cur_n  = cur_inc;
      if (commit) base_n = cur_inc;
      if (rewind) cur_n  = base_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else begin
      base_addr <= base_n;
      cur_addr  <= cur_n;
    end
  end

endmodule

// File: rtl/txr_retry_dma.sv
module txr_retry_dma #(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 12,
  parameter int CHAIN_W    = 4,
  parameter int SLOT_BYTES = 64,
  parameter int MAX_RETRY  = 15,
  parameter int BO_LIMIT   = 10,
  localparam int ATT_W     = $clog2(MAX_RETRY + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [CHAIN_W-1:0] chain_len,
  input  logic               medium_idle,
  input  logic               col,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_done,
  output logic               tx_abort,
  output logic               abort_late,
  output logic [ATT_W-1:0]   attempts,
  output logic               busy
);

  import txr_pkg::*;

  localparam logic [ATT_W-1:0] COL_CAP = ATT_W'(MAX_RETRY + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  txr_state_e         st_q, st_n;
  logic [LEN_W-1:0]   bcnt_q, bcnt_n, len_q, len_n;
  logic [1:0]         jcnt_q, jcnt_n;
  logic [ATT_W-1:0]   ncol_q, ncol_n, att_q, att_n;
  logic [CHAIN_W-1:0] left_q, left_n;
  logic               late_q, late_n, latef_q, latef_n;
  logic               done_n, abort_n;
  logic               issue, jam_out;
  logic               a_load, a_step, a_rewind, a_commit, bo_load, bo_done;
  logic               last_byte, last_frame, late_now;
  logic [ADDR_W-1:0]  base_addr, cur_addr;
  logic [15:0]        rnd;

  txr_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .load(a_load), .load_val(start_addr),
    .step(a_step), .rewind(a_rewind), .commit(a_commit),
    .base_addr(base_addr), .cur_addr(cur_addr)
  );

  txr_lfsr #(.W(16)) u_lfsr (.clk(clk), .rst_n(rst_i_n), .rnd(rnd));

  txr_backoff #(
    .SLOT_BYTES(SLOT_BYTES), .BO_LIMIT(BO_LIMIT), .CNT_W(ATT_W)
  ) u_bo (
    .clk(clk), .rst_n(rst_i_n), .load(bo_load), .ncol(ncol_q),
    .rnd(rnd), .done(bo_done)
  );

  assign last_byte  = ({1'b0, bcnt_q} + (LEN_W + 1)'(1)) >= {1'b0, len_q};
  assign last_frame = left_q <= CHAIN_W'(1);
  assign late_now   = bcnt_q >= LEN_W'(SLOT_BYTES);

  always_comb begin
    st_n     = st_q;
    bcnt_n   = bcnt_q;
    jcnt_n   = jcnt_q;
    ncol_n   = ncol_q;
    late_n   = late_q;
    len_n    = len_q;
    left_n   = left_q;
    att_n    = att_q;
    latef_n  = latef_q;
    done_n   = 1'b0;
    abort_n  = 1'b0;
    issue    = 1'b0;
    jam_out  = 1'b0;
    a_load   = 1'b0;
    a_step   = 1'b0;
    a_rewind = 1'b0;
    a_commit = 1'b0;
    bo_load  = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        a_load = 1'b1;
        len_n  = frame_len;
        left_n = chain_len;
        ncol_n = '0;
        st_n   = S_WAIT;
      end
      S_WAIT: if (medium_idle) begin
        bcnt_n = '0;
        st_n   = S_SEND;
      end
      S_SEND: begin
        if (col) begin
          ncol_n = ncol_q + ATT_W'(1);
          late_n = late_now;
          jcnt_n = '0;
          st_n   = S_JAM;
        end else begin
          issue  = 1'b1;
          a_step = 1'b1;
          bcnt_n = bcnt_q + LEN_W'(1);
          if (last_byte) begin
            a_commit = 1'b1;
            done_n   = 1'b1;
            att_n    = ncol_q;
            latef_n  = 1'b0;
            ncol_n   = '0;
            left_n   = left_q - CHAIN_W'(1);
            st_n     = last_frame ? S_IDLE : S_WAIT;
          end
        end
      end
      S_JAM: begin
        issue   = 1'b1;
        jam_out = 1'b1;
        jcnt_n  = jcnt_q + 2'd1;
        if (jcnt_q == 2'(JAM_LEN - 1)) begin
          if (late_q || (ncol_q == COL_CAP)) begin
            abort_n = 1'b1;
            att_n   = ncol_q;
            latef_n = late_q;
            ncol_n  = '0;
            st_n    = S_IDLE;
          end else begin
            bo_load = 1'b1;
            st_n    = S_BACK;
          end
        end
      end
      S_BACK: if (bo_done) begin
        a_rewind = 1'b1;
        st_n     = S_WAIT;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= S_IDLE;
      bcnt_q  <= '0;
      jcnt_q  <= '0;
      ncol_q  <= '0;
      late_q  <= 1'b0;
      len_q   <= '0;
      left_q  <= '0;
      att_q   <= '0;
      latef_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      bcnt_q  <= bcnt_n;
      jcnt_q  <= jcnt_n;
      ncol_q  <= ncol_n;
      late_q  <= late_n;
      len_q   <= len_n;
      left_q  <= left_n;
      att_q   <= att_n;
      latef_q <= latef_n;
    end
  end

  // output stage
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_done  <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      tx_valid <= issue;
      tx_done  <= done_n;
      tx_abort <= abort_n;
      if (issue) tx_data <= jam_out ? JAM_BYTE : mem_rd_data;
    end
  end

  assign mem_rd_en  = (st_q == S_SEND);
  assign mem_addr   = cur_addr;
  assign attempts   = att_q;
  assign abort_late = latef_q;
  assign busy       = (st_q != S_IDLE);

endmodule

// File: rtl/txr_retry_chk.sv
module txr_retry_chk #(
  parameter int ADDR_W    = 16,
  parameter int ATT_W     = 5,
  parameter int MAX_RETRY = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                col,
  input logic                medium_idle,
  input logic                tx_valid,
  input logic [7:0]          tx_data,
  input logic                tx_done,
  input logic                tx_abort,
  input logic [ATT_W-1:0]    ncol,
  input txr_pkg::txr_state_e st,
  input logic [ADDR_W-1:0]   base_addr,
  input logic [ADDR_W-1:0]   cur_addr
);

  import txr_pkg::*;

  a_r10_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_done, tx_abort}) <= 1);

  a_r10_col_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ncol <= ATT_W'(MAX_RETRY + 1));

  a_r3_quiet_when_busy_medium: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !medium_idle) |=> !tx_valid);

  a_r4_jam_follows_col: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && col) |=> ##1 (tx_valid && tx_data == JAM_BYTE));

  a_r6_rewind_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && $past(st) == S_BACK) |-> (cur_addr == base_addr));

  a_r7_base_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_addr) |-> (tx_done || $past(st == S_IDLE && start)));

endmodule

bind txr_retry_dma txr_retry_chk #(
  .ADDR_W(ADDR_W), .ATT_W(ATT_W), .MAX_RETRY(MAX_RETRY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .col(col),
  .medium_idle(medium_idle), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_done(tx_done), .tx_abort(tx_abort), .ncol(ncol_q), .st(st_q),
  .base_addr(base_addr), .cur_addr(cur_addr)
);

// File: tb/tb_txr_retry_dma.sv
module tb_txr_retry_dma;

  localparam int SLOT = 8;
  localparam int AW   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [11:0] frame_len = '0;
  logic [3:0]  chain_len = '0;
  logic        medium_idle = 1'b1;
  logic        col;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rd_data;
  logic        tx_valid, tx_done, tx_abort, abort_late, busy;
  logic [7:0]  tx_data;
  logic [4:0]  attempts;

  always #4 clk = ~clk;

  // buffer memory: data never equals the jam value (bit 7 clear)
  assign mem_rd_data = {1'b0, mem_addr[6:0]};

  txr_retry_dma #(.ADDR_W(AW), .SLOT_BYTES(SLOT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .frame_len(frame_len), .chain_len(chain_len), .medium_idle(medium_idle),
    .col(col), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_done(tx_done), .tx_abort(tx_abort), .abort_late(abort_late),
    .attempts(attempts), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // captured stream, owned by the monitor
  int sb [0:4095];
  int sc [0:4095];
  int ns, ndone, nabort, ab_att, ab_late, excl_viol, cyc;
  int done_att [0:15];
  int att_bytes, fired_total;
  bit fired;
  // collision plan, owned by the stimulus
  int col_at, col_limit, col_frame;

  initial col = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (start) begin
      ns = 0; ndone = 0; nabort = 0; att_bytes = 0; fired = 0; fired_total = 0;
    end
    if (tx_valid && ns < 4096) begin
      sb[ns] = int'(tx_data);
      sc[ns] = cyc;
      ns++;
      if (tx_data == 8'hAA) begin att_bytes = 0; fired = 0; end
      else att_bytes++;
    end
    if (tx_done && tx_abort) excl_viol++;
    if (tx_done) begin
      if (ndone < 16) done_att[ndone] = int'(attempts);
      ndone++; att_bytes = 0; fired = 0;
    end
    if (tx_abort) begin
      nabort++; ab_att = int'(attempts); ab_late = int'(abort_late);
    end
    if (busy && !fired && fired_total < col_limit && ndone == col_frame &&
        att_bytes == col_at) begin
      col = 1'b1; fired = 1; fired_total++;
    end else begin
      col = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int eb [0:4095];
  int ne;
  int exp_att [0:15];

  task automatic push_seq(input int b, input int n);
    for (int i = 0; i < n; i++) begin eb[ne] = (b + i) & 127; ne++; end
  endtask

  task automatic push_jam();
    for (int i = 0; i < 4; i++) begin eb[ne] = 8'hAA; ne++; end
  endtask

  task automatic run_case(input string tag, input int base, input int len,
                          input int nfr, input int cf, input int cat,
                          input int clim, input bit hold);
    int e_done, e_abort, e_aatt, e_alate, held_ns, mism, gap_bad, jidx, guard;
    bit stop;
    ne = 0; e_done = 0; e_abort = 0; e_aatt = 0; e_alate = 0; stop = 0;
    for (int f = 0; f < nfr && !stop; f++) begin
      int b = base + f * len;
      if (f == cf) begin
        for (int j = 1; j <= clim && !stop; j++) begin
          push_seq(b, cat); push_jam();
          if (cat >= SLOT) begin e_abort = 1; e_aatt = j; e_alate = 1; stop = 1; end
          else if (j == 16) begin e_abort = 1; e_aatt = 16; e_alate = 0; stop = 1; end
        end
      end
      if (!stop) begin
        push_seq(b, len);
        exp_att[e_done] = (f == cf) ? clim : 0;
        e_done++;
      end
    end
    @(posedge clk); #1;
    start_addr = 16'(base); frame_len = 12'(len); chain_len = 4'(nfr);
    col_at = cat; col_limit = (cf >= 0) ? clim : 0; col_frame = cf;
    medium_idle = !hold; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    held_ns = 0;
    if (hold) begin
      repeat (20) @(posedge clk);
      #1; held_ns = ns; medium_idle = 1'b1;
    end
    guard = 0;
    do begin @(negedge clk); guard++; end while (busy && guard < 150000);
    repeat (3) @(negedge clk);

    mism = (ns != ne) ? 1 : 0;
    for (int i = 0; i < ns && i < ne; i++) if (sb[i] != eb[i]) mism++;
    chk(mism == 0, {tag, " R2 R4 R6 byte stream"}, ns, ne);
    chk(ndone == e_done, {tag, " R7 frames completed"}, ndone, e_done);
    mism = 0;
    for (int i = 0; i < ndone && i < 16; i++) if (done_att[i] != exp_att[i]) mism++;
    chk(mism == 0, {tag, " R2 collision count at done"}, mism, 0);
    chk(nabort == e_abort, {tag, " R8 R9 abort count"}, nabort, e_abort);
    if (e_abort != 0) begin
      chk(ab_att == e_aatt, {tag, " R9 attempts at abort"}, ab_att, e_aatt);
      chk(ab_late == e_alate, {tag, " R8 late flag"}, ab_late, e_alate);
    end
    // backoff gaps: r*SLOT + 2 idle clocks, r < 2^min(j,10)
    gap_bad = 0; jidx = 0;
    for (int i = 0; i + 1 < ns; i++) begin
      if (sb[i] == 8'hAA && sb[i+1] != 8'hAA) begin
        int g, k;
        jidx++;
        g = sc[i+1] - sc[i] - 1;
        k = (jidx < 10) ? jidx : 10;
        if (g < 2 || ((g - 2) % SLOT) != 0 || ((g - 2) / SLOT) > ((1 << k) - 1))
          gap_bad++;
      end
    end
    chk(gap_bad == 0, {tag, " R5 backoff gap form"}, gap_bad, 0);
    if (hold) chk(held_ns == 0, {tag, " R3 no byte while medium busy"}, held_ns, 0);
  endtask

  initial begin
    col_at = 0; col_limit = 0; col_frame = -1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !tx_valid, "R1 idle after reset", int'(busy), 0);
    chk(!tx_done && !tx_abort, "R1 no status pulse after reset", int'(tx_done), 0);
    chk(attempts == 0, "R1 attempts after reset", int'(attempts), 0);

    // near-exhaustive sweep of the collision position across the slot edge
    for (int c = 1; c <= 10; c++) run_case($sformatf("sweep c=%0d", c), 16, 12, 1, 0, c, 1, 0);
    run_case("three early collisions", 32, 12, 1, 0, 3, 3, 0);
    run_case("R7 chain retry mid", 16, 12, 3, 1, 5, 2, 0);
    run_case("R7 chain clean", 64, 5, 4, -1, 0, 0, 0);
    run_case("R8 late in chain", 16, 12, 3, 1, 9, 1, 0);
    run_case("R9 excessive", 64, 12, 2, 0, 2, 16, 0);
    run_case("R3 medium busy", 32, 6, 1, -1, 0, 0, 1);
    run_case("after abort restart", 80, 10, 2, 1, 1, 15, 0);
    chk(excl_viol == 0, "R10 done and abort together", excl_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule